// File: doc/BRIEF.md
# Priority-Muxed Eight-Pin GPIO Port

This block is one eight-pin general-purpose I/O port. Software reaches it through a small synchronous register bus with three registers. The output-value register holds the levels driven on pins that software owns. The direction register sets which of those pins drive. The read-only sampled-pin register shows the levels actually present on the pads. The port also decides who owns each pin. A CAN controller uses two dedicated pins. A second, routed CAN controller and an SPI controller share two other pins. Any pin that no peripheral claims falls back to plain GPIO.

Ownership is settled per pin by a fixed priority. When a peripheral takes a pin it may force that pin's direction, but the stored direction bits are never rewritten. Turning the peripheral off therefore hands the pin back exactly as software left it. Pad inputs pass through a synchronizer. The sampled-pin register stays cleared for a short settling window after reset and then tracks the pads, whoever drives them. Software can compare it with the output-value register to spot a shorted or overloaded output.

Top module: `gpio_muxport`

## Requirements
- R1: While reset is held and right after it is released, the output-value and direction registers read 0x00, every pin_oe bit is 0 and every pin_out bit is 0.
- R2: Address 0 selects the output-value register and address 1 the direction register. A write lands on the clock edge where bus_we is high. A read returns the addressed register on bus_rdata after the next clock edge.
- R3: A pin owned by no peripheral has pin_oe equal to its direction bit (1 = output) and pin_out equal to its output-value bit. Both outputs update on the clock edge after the register changes.
- R4: A write to address 2 (sampled-pin register) changes nothing: a later read still returns the pad levels, and the other registers keep their values.
- R5: Reading address 2 returns the pad levels synchronized over two edges and then registered, whatever each pin's direction or owner. A pin driven high by software but held low at the pad reads 0.
- R6: After reset is released, the sampled-pin register stays 0x00 through the first two clock edges and loads the synchronized pads on the third.
- R7: While can_en is 1, pin 1 is an output carrying can_tx and pin 0 is an input, with pin_out showing its output-value bit. The direction register reads back unchanged.
- R8: While rcan_en is 1, pin 5 is an output carrying rcan_tx and pin 4 is an input. This holds even when SPI is active, because routed CAN ranks above SPI, and SPI ranks above GPIO.
- R9: SPI owns pin 4 (MISO: pin_oe = spi_miso_oe, pin_out = spi_miso_o) and pin 5 (slave select: pin_oe = spi_ss_oe, pin_out = spi_ss_o) only while spi_en is 1 and spi_bidir is 0. Otherwise those pins follow R3.
- R10: Address 3 reads 0x00, and a write to it leaves every register unchanged.
- R11: periph_in shows the pad levels after two clock edges of synchronization.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| can_en | input | 1 | CAN controller enabled (pins 0 and 1) |
| can_tx | input | 1 | CAN transmit level |
| rcan_en | input | 1 | Routed CAN controller enabled (pins 4 and 5) |
| rcan_tx | input | 1 | Routed CAN transmit level |
| spi_en | input | 1 | SPI controller enabled |
| spi_bidir | input | 1 | SPI in single-wire bidirectional mode |
| spi_miso_oe | input | 1 | SPI drives MISO |
| spi_miso_o | input | 1 | SPI MISO level |
| spi_ss_oe | input | 1 | SPI drives slave select |
| spi_ss_o | input | 1 | SPI slave-select level |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| periph_in | output | 8 | Synchronized pad levels for peripherals |

## Verification
The settling window after reset is the hardest part to reach, since it lasts only a few edges and nothing but reset creates it. The stimulus sets the pad levels while reset is still asserted, keeps the bus pointed at the sampled-pin register, and checks each read edge by edge after release. The priority conflict on the shared pins is reached from a table of enable combinations that turns on routed CAN and SPI together, and also sets SPI's bidirectional mode. A short at an output is modelled by driving pads opposite to the written output value.

// File: rtl/gpio_muxport_pkg.sv
package gpio_muxport_pkg;
  typedef enum logic [1:0] {
    OWN_GPIO = 2'd0,
    OWN_SPI  = 2'd1,
    OWN_RCAN = 2'd2,
    OWN_CAN  = 2'd3
  } pin_owner_e;

  localparam int ADDR_OUTVAL  = 0;
  localparam int ADDR_DIR     = 1;
  localparam int ADDR_SAMPLED = 2;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_muxport_pkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      sampled,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      outval_q,
  output logic [W-1:0]      dir_q
);
  localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(ADDR_OUTVAL);
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(ADDR_DIR);
  localparam logic [ADDR_W-1:0] A_SMP = ADDR_W'(ADDR_SAMPLED);

  logic [W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (addr == A_OUT)      rd_mux = outval_q;
    else if (addr == A_DIR) rd_mux = dir_q;
    else if (addr == A_SMP) rd_mux = sampled;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outval_q <= '0;
      dir_q    <= '0;
      rdata    <= '0;
    end else begin
      if (we && addr == A_OUT) outval_q <= wdata;
      if (we && addr == A_DIR) dir_q    <= wdata;
      rdata <= rd_mux;
    end
  end

  // R1: registers come out of reset cleared
  a_r1_regs_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (outval_q == '0 && dir_q == '0));

  // R2: a direction write lands on its edge
  a_r2_dir_write: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_DIR) |=> (dir_q == $past(wdata)));

  // R10: writes outside the mapped registers leave both unchanged
  a_r10_unmapped_write: assert property (@(posedge clk) disable iff (rst)
    (we && addr != A_OUT && addr != A_DIR) |=> ($stable(dir_q) && $stable(outval_q)));
endmodule

// File: rtl/gpio_insync.sv
module gpio_insync #(
  parameter int W      = 8,
  parameter int STAGES = 2,
  parameter int SETTLE = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] sync_out,
  output logic [W-1:0] sampled_q
);
  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(SETTLE);

  logic [W-1:0]     sync_q [STAGES];
  logic [CNT_W-1:0] settle_cnt;
  logic             ready;

  // synchronizer flops are not reset so the pads are tracked during reset
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) sync_q[s] <= pin_in;
    end else begin : g_next
      always_ff @(posedge clk) sync_q[s] <= sync_q[s-1];
    end
  end

  assign sync_out = sync_q[STAGES-1];
  assign ready    = (settle_cnt == CNT_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      settle_cnt <= '0;
      sampled_q  <= '0;
    end else begin
      if (!ready) settle_cnt <= settle_cnt + 1'b1;
      if (ready)  sampled_q  <= sync_out;
    end
  end

  // R6: sampled register stays clear until the settling window ends
  a_r6_settle_clear: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (sampled_q == '0));

  // R6: once settled the register tracks the synchronizer output
  a_r6_settle_track: assert property (@(posedge clk) disable iff (rst)
    ready |=> (sampled_q == $past(sync_out)));
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_muxport_pkg::*;
#(
  parameter int W            = 8,
  parameter int CAN_RX_PIN   = 0,
  parameter int CAN_TX_PIN   = 1,
  parameter int RCAN_RX_PIN  = 4,
  parameter int RCAN_TX_PIN  = 5,
  parameter int SPI_MISO_PIN = 4,
  parameter int SPI_SS_PIN   = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] outval_q,
  input  logic [W-1:0] dir_q,
  input  logic         can_en,
  input  logic         can_tx,
  input  logic         rcan_en,
  input  logic         rcan_tx,
  input  logic         spi_en,
  input  logic         spi_bidir,
  input  logic         spi_miso_oe,
  input  logic         spi_miso_o,
  input  logic         spi_ss_oe,
  input  logic         spi_ss_o,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  logic         spi_act;
  logic [W-1:0] nxt_oe;
  logic [W-1:0] nxt_out;

  assign spi_act = spi_en && !spi_bidir;

  for (genvar i = 0; i < W; i++) begin : g_pin
    localparam bit IS_CAN    = (i == CAN_RX_PIN)  || (i == CAN_TX_PIN);
    localparam bit IS_CANTX  = (i == CAN_TX_PIN);
    localparam bit IS_RCAN   = (i == RCAN_RX_PIN) || (i == RCAN_TX_PIN);
    localparam bit IS_RCANTX = (i == RCAN_TX_PIN);
    localparam bit IS_MISO   = (i == SPI_MISO_PIN);
    localparam bit IS_SS     = (i == SPI_SS_PIN);

    pin_owner_e owner;
    logic       oe_b;
    logic       out_b;

    // lowest priority first, each later test overrides
    always_comb begin
      owner = OWN_GPIO;
      if (spi_act && (IS_MISO || IS_SS)) owner = OWN_SPI;
      if (rcan_en && IS_RCAN)            owner = OWN_RCAN;
      if (can_en && IS_CAN)              owner = OWN_CAN;
    end

    always_comb begin
      oe_b  = dir_q[i];
      out_b = outval_q[i];
      case (owner)
        OWN_CAN: begin
          oe_b  = IS_CANTX;
          out_b = IS_CANTX ? can_tx : outval_q[i];
        end
        OWN_RCAN: begin
          oe_b  = IS_RCANTX;
          out_b = IS_RCANTX ? rcan_tx : outval_q[i];
        end
        OWN_SPI: begin
          oe_b  = IS_MISO ? spi_miso_oe : spi_ss_oe;
          out_b = IS_MISO ? spi_miso_o  : spi_ss_o;
        end
        default: begin
          oe_b  = dir_q[i];
          out_b = outval_q[i];
        end
      endcase
    end

    assign nxt_oe[i]  = oe_b;
    assign nxt_out[i] = out_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe  <= '0;
      pin_out <= '0;
    end else begin
      pin_oe  <= nxt_oe;
      pin_out <= nxt_out;
    end
  end

  // R1: every pin is an input right after reset
  a_r1_pins_input: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0));

  // R3: with no peripheral active the pads follow the registers
  a_r3_gpio_follow: assert property (@(posedge clk) disable iff (rst)
    (!can_en && !rcan_en && !spi_act) |=>
      (pin_oe == $past(dir_q) && pin_out == $past(outval_q)));

  // R7: CAN transmit pin drives, receive pin listens
  a_r7_can_dirs: assert property (@(posedge clk) disable iff (rst)
    can_en |=> (pin_oe[CAN_TX_PIN] && !pin_oe[CAN_RX_PIN]
                && pin_out[CAN_TX_PIN] == $past(can_tx)));

  // R8: routed CAN wins its pins regardless of SPI
  a_r8_rcan_wins: assert property (@(posedge clk) disable iff (rst)
    (rcan_en && !can_en) |=> (pin_oe[RCAN_TX_PIN] && !pin_oe[RCAN_RX_PIN]
                && pin_out[RCAN_TX_PIN] == $past(rcan_tx)));
endmodule

// File: rtl/gpio_muxport.sv
module gpio_muxport
  import gpio_muxport_pkg::*;
#(
  parameter int W            = 8,
  parameter int ADDR_W       = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int SETTLE       = 2,
  parameter int CAN_RX_PIN   = 0,
  parameter int CAN_TX_PIN   = 1,
  parameter int RCAN_RX_PIN  = 4,
  parameter int RCAN_TX_PIN  = 5,
  parameter int SPI_MISO_PIN = 4,
  parameter int SPI_SS_PIN   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic              can_en,
  input  logic              can_tx,
  input  logic              rcan_en,
  input  logic              rcan_tx,
  input  logic              spi_en,
  input  logic              spi_bidir,
  input  logic              spi_miso_oe,
  input  logic              spi_miso_o,
  input  logic              spi_ss_oe,
  input  logic              spi_ss_o,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic [W-1:0]      periph_in
);
  logic [W-1:0] outval_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] sampled_q;

  gpio_insync #(.W(W), .STAGES(SYNC_STAGES), .SETTLE(SETTLE)) u_insync (
    .clk       (clk),
    .rst       (rst),
    .pin_in    (pin_in),
    .sync_out  (periph_in),
    .sampled_q (sampled_q)
  );

  gpio_regs #(.W(W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .we       (bus_we),
    .wdata    (bus_wdata),
    .sampled  (sampled_q),
    .rdata    (bus_rdata),
    .outval_q (outval_q),
    .dir_q    (dir_q)
  );

  gpio_pinmux #(
    .W(W), .CAN_RX_PIN(CAN_RX_PIN), .CAN_TX_PIN(CAN_TX_PIN),
    .RCAN_RX_PIN(RCAN_RX_PIN), .RCAN_TX_PIN(RCAN_TX_PIN),
    .SPI_MISO_PIN(SPI_MISO_PIN), .SPI_SS_PIN(SPI_SS_PIN)
  ) u_pinmux (
    .clk         (clk),
    .rst         (rst),
    .outval_q    (outval_q),
    .dir_q       (dir_q),
    .can_en      (can_en),
    .can_tx      (can_tx),
    .rcan_en     (rcan_en),
    .rcan_tx     (rcan_tx),
    .spi_en      (spi_en),
    .spi_bidir   (spi_bidir),
    .spi_miso_oe (spi_miso_oe),
    .spi_miso_o  (spi_miso_o),
    .spi_ss_oe   (spi_ss_oe),
    .spi_ss_o    (spi_ss_o),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe)
  );
endmodule

// File: tb/test_gpio_muxport.sv
module test_gpio_muxport;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       can_en, can_tx, rcan_en, rcan_tx, spi_en, spi_bidir;
  logic       spi_miso_oe, spi_miso_o, spi_ss_oe, spi_ss_o;
  logic [7:0] pin_in, pin_out, pin_oe, periph_in;

  int  checks   = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_muxport i_gpio_muxport (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .can_en(can_en), .can_tx(can_tx), .rcan_en(rcan_en), .rcan_tx(rcan_tx),
    .spi_en(spi_en), .spi_bidir(spi_bidir),
    .spi_miso_oe(spi_miso_oe), .spi_miso_o(spi_miso_o),
    .spi_ss_oe(spi_ss_oe), .spi_ss_o(spi_ss_o),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .periph_in(periph_in)
  );

  // {can_en, rcan_en, spi_en, spi_bidir} | dir | outval | expected oe | expected out
  // fixed peripheral levels: can_tx=1 rcan_tx=0 miso_oe=1 miso_o=1 ss_oe=0 ss_o=1
  localparam int NVEC = 8;
  localparam logic [35:0] VEC [NVEC] = '{
    {4'b0000, 8'hA5, 8'h3C, 8'hA5, 8'h3C},  // R3 plain GPIO
    {4'b1000, 8'hFF, 8'h00, 8'hFE, 8'h02},  // R7 CAN forces pins 0/1
    {4'b0100, 8'h00, 8'hFF, 8'h20, 8'hDF},  // R8 routed CAN alone
    {4'b0110, 8'h0F, 8'hF0, 8'h2F, 8'hD0},  // R8 routed CAN beats SPI
    {4'b0010, 8'h00, 8'h00, 8'h10, 8'h30},  // R9 SPI owns pins 4/5
    {4'b0011, 8'h30, 8'h00, 8'h30, 8'h00},  // R9 bidir mode leaves GPIO
    {4'b1110, 8'h00, 8'h00, 8'h22, 8'h02},  // R8 both CANs, SPI loses
    {4'b1010, 8'hC0, 8'h55, 8'hD2, 8'h77}   // R9 CAN plus SPI on separate pins
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    bus_we   = 1'b0;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    rst = 1'b1; bus_addr = 2'd2; bus_we = 1'b0; bus_wdata = 8'h00;
    can_en = 0; rcan_en = 0; spi_en = 0; spi_bidir = 0;
    can_tx = 1; rcan_tx = 0; spi_miso_oe = 1; spi_miso_o = 1;
    spi_ss_oe = 0; spi_ss_o = 1;
    pin_in = 8'hC3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 pin_oe in reset", pin_oe, 8'h00);
    rst = 1'b0;

    // startup window, bus held on address 2
    @(posedge clk); @(negedge clk);
    check("R1 pin_oe after release", pin_oe, 8'h00);
    check("R1 pin_out after release", pin_out, 8'h00);
    check("R6 read after edge 1", bus_rdata, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R6 read after edge 2", bus_rdata, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R6 read after edge 3", bus_rdata, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R6 read after edge 4", bus_rdata, 8'hC3);

    bus_read(2'd0, rd); check("R1 outval reset", rd, 8'h00);
    bus_read(2'd1, rd); check("R1 dir reset", rd, 8'h00);

    // table of ownership vectors
    for (int v = 0; v < NVEC; v++) begin
      {can_en, rcan_en, spi_en, spi_bidir} = VEC[v][35:32];
      bus_write(2'd1, VEC[v][31:24]);
      bus_write(2'd0, VEC[v][23:16]);
      @(posedge clk); @(negedge clk);
      check($sformatf("R3/R7/R8/R9 pin_oe vec %0d", v), pin_oe, VEC[v][15:8]);
      check($sformatf("R3/R7/R8/R9 pin_out vec %0d", v), pin_out, VEC[v][7:0]);
      bus_read(2'd1, rd);
      check($sformatf("R7 dir kept vec %0d", v), rd, VEC[v][31:24]);
    end
    can_en = 0; rcan_en = 0; spi_en = 0; spi_bidir = 0;

    // R2 write then read back
    bus_write(2'd0, 8'h3C);
    bus_read(2'd0, rd); check("R2 outval readback", rd, 8'h3C);

    // R5 pins driven low by software but pads held elsewhere (short)
    bus_write(2'd1, 8'hFF);
    bus_write(2'd0, 8'h00);
    pin_in = 8'hA5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 driven outputs", pin_out, 8'h00);
    bus_read(2'd2, rd); check("R5 sampled shows pads", rd, 8'hA5);

    // R4 write to sampled register ignored
    bus_write(2'd2, 8'hFF);
    bus_read(2'd2, rd); check("R4 sampled unchanged", rd, 8'hA5);
    bus_read(2'd0, rd); check("R4 outval unchanged", rd, 8'h00);
    bus_read(2'd1, rd); check("R4 dir unchanged", rd, 8'hFF);

    // R10 unmapped address
    bus_write(2'd3, 8'h77);
    bus_read(2'd3, rd); check("R10 unmapped reads zero", rd, 8'h00);
    bus_read(2'd0, rd); check("R10 outval unchanged", rd, 8'h00);
    bus_read(2'd1, rd); check("R10 dir unchanged", rd, 8'hFF);

    // R11 synchronizer depth
    pin_in = 8'h0F;
    @(posedge clk); @(negedge clk);
    check("R11 periph_in after 1 edge", periph_in, 8'hA5);
    @(posedge clk); @(negedge clk);
    check("R11 periph_in after 2 edges", periph_in, 8'h0F);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule